// File: doc/BRIEF.md
# Serial Link Training State Sequencer

This block is the top-level controller of a serial link's bring-up and power-state flow. It moves between eleven states: the training phases, normal operation, a fast idle side state, two low-power states, a retraining state, and three special states (Hot Reset, Loopback, Disable). The lower phases (receiver detection, polling, configuration, recovery) are not modelled here. Each of them reports back through a done strobe and a timeout strobe.

Received ordered sets arrive one per cycle at most. Each is marked by a valid flag, a 2-bit kind code, and two decoded TS1 control bits (loopback and hot reset). Loopback and Hot Reset are only taken after a run of back-to-back qualifying TS1s. Idle cycles without an ordered set do not break such a run. The block registers its outputs: a 4-bit state code and a link-up flag.

Top module: `link_train_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the machine in Detect with `link_up` low. The state codes are Detect 0, Polling 1, Configuration 2, Recovery 3, L0 4, L0s 5, L1 6, L2 7, Hot Reset 8, Loopback 9, Disable 10, and `st_code` never shows any other value.
- R2: Bring-up runs Detect to Polling on `det_done`, Polling to Configuration on `poll_done`, and Configuration to L0 on `cfg_done`. Each step happens on the clock edge that samples its strobe, and with no strobe the state holds.
- R3: `poll_tmo` in Polling, `cfg_tmo` in Configuration and `rec_tmo` in Recovery each return the machine to Detect. A done strobe wins over a timeout raised in the same cycle.
- R4: In Configuration or Recovery, Loopback is entered on the edge that samples the PAIR_NEED-th (default 2) back-to-back valid ordered set of kind TS1 (`os_type` = 0) with `os_lpbk` = 1. Qualifying TS1s seen in any other state cause no transition.
- R5: The same rule applies to Hot Reset, counted on TS1s with `os_hrst` = 1. When both runs complete on the same edge, Hot Reset wins over Loopback, and both win over the phase done and timeout strobes.
- R6: Each run count returns to zero on a TS1 without its bit, on any other kind (TS2 = 1, EIOS = 2, other = 3), and on every state change. Cycles with `os_vld` low leave the count unchanged.
- R7: Hot Reset lasts exactly HRST_CYCLES cycles and then returns to Detect with no input needed.
- R8: In L0, a valid ordered set of kind EIOS (`os_type` = 2) moves to L0s. L0s returns to L0 on `fts_lock` and ignores every other input.
- R9: L1 is entered only from L0 and only on `pm_l1_req`. In L1, `pm_l2_req` moves to L2 and `wake` moves to Recovery. In L2, `wake` moves to Detect. `pm_l2_req` and `wake` have no effect in L0.
- R10: `retrain` in L0 moves to Recovery, and `rec_done` in Recovery moves to L0.
- R11: `link_up` is 1 exactly while the state is L0, L0s, L1 or Recovery.
- R12: `link_dis` high in Configuration, Recovery or L0 moves to Disable. The machine stays in Disable while `link_dis` is high and goes to Detect once it is low.
- R13: In Loopback, a valid EIOS moves to Detect. Any other input leaves the state unchanged.
- R14: When several requests arrive together in L0, they are served in this order: `link_dis`, then `retrain`, then EIOS, then `pm_l1_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_done | input | 1 | Receiver detection finished with a partner present |
| poll_done | input | 1 | Polling phase finished |
| poll_tmo | input | 1 | Polling phase timed out |
| cfg_done | input | 1 | Configuration phase finished |
| cfg_tmo | input | 1 | Configuration phase timed out |
| rec_done | input | 1 | Recovery relock finished |
| rec_tmo | input | 1 | Recovery timed out |
| os_vld | input | 1 | An ordered set was received this cycle |
| os_type | input | 2 | Ordered set kind: 0 TS1, 1 TS2, 2 EIOS, 3 other |
| os_lpbk | input | 1 | Loopback control bit of the received TS1 |
| os_hrst | input | 1 | Hot-reset control bit of the received TS1 |
| fts_lock | input | 1 | Lock regained by fast training sequences |
| retrain | input | 1 | Request to retrain or change bandwidth |
| pm_l1_req | input | 1 | Negotiated request to enter L1 |
| pm_l2_req | input | 1 | Request to go from L1 to L2 |
| wake | input | 1 | Exit request from L1 or L2 |
| link_dis | input | 1 | Level request to disable the link |
| st_code | output | 4 | Current state code |
| link_up | output | 1 | Link operational flag |

## Verification
The bench builds the block with PAIR_NEED at its default of 2 and HRST_CYCLES reduced to 5. This makes the end of the Hot Reset dwell, and the cycle just before it, visible within a handful of cycles. With two-deep runs, the bench can test the boundary cases directly: a run broken by a TS1 without the bit, a run broken by a TS2 carrying the bit, a run that continues across an idle cycle, and pairs arriving in states where they must be ignored.

// File: rtl/lts_pkg.sv
package lts_pkg;

  typedef enum logic [3:0] {
    ST_DETECT   = 4'd0,
    ST_POLLING  = 4'd1,
    ST_CONFIG   = 4'd2,
    ST_RECOVERY = 4'd3,
    ST_L0       = 4'd4,
    ST_L0S      = 4'd5,
    ST_L1       = 4'd6,
    ST_L2       = 4'd7,
    ST_HOTRST   = 4'd8,
    ST_LOOPBACK = 4'd9,
    ST_DISABLED = 4'd10
  } lts_state_e;

  typedef enum logic [1:0] {
    OS_TS1   = 2'd0,
    OS_TS2   = 2'd1,
    OS_EIOS  = 2'd2,
    OS_OTHER = 2'd3
  } os_kind_e;

  function automatic logic state_is_up(input lts_state_e s);
    case (s)
      ST_L0, ST_L0S, ST_L1, ST_RECOVERY: state_is_up = 1'b1;
      default:                           state_is_up = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lts_ts1_run.sv
module lts_ts1_run #(
  parameter int NEED = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic os_vld,
  input  logic os_is_ts1,
  input  logic os_bit,
  output logic hit
);
  localparam int CW  = (NEED < 2) ? 1 : $clog2(NEED + 1);
  localparam int TOP = (NEED < 2) ? 0 : NEED - 1;

  logic [CW-1:0] cnt_q;
  logic          qual;

  assign qual = os_vld && os_is_ts1 && os_bit;
  assign hit  = qual && (cnt_q == CW'(TOP));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (os_vld) begin
      if (!qual)                   cnt_q <= '0;
      else if (cnt_q != CW'(TOP))  cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_RUN_SAT: assert property (@(posedge clk) disable iff (rst) cnt_q <= CW'(TOP)); // R6
  AST_RUN_BREAK: assert property (@(posedge clk) disable iff (rst)
    (os_vld && !qual) |=> (cnt_q == '0)); // R6
  AST_RUN_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!os_vld && !clr) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/lts_dwell.sv
module lts_dwell #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == CW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  AST_DWELL_RANGE: assert property (@(posedge clk) disable iff (rst) cnt_q < CW'(CYCLES)); // R7

endmodule

// File: rtl/lts_next.sv
module lts_next
  import lts_pkg::*;
(
  input  lts_state_e cur,
  input  logic       det_done,
  input  logic       poll_done,
  input  logic       poll_tmo,
  input  logic       cfg_done,
  input  logic       cfg_tmo,
  input  logic       rec_done,
  input  logic       rec_tmo,
  input  logic       eios_seen,
  input  logic       hit_lpbk,
  input  logic       hit_hrst,
  input  logic       fts_lock,
  input  logic       retrain,
  input  logic       pm_l1_req,
  input  logic       pm_l2_req,
  input  logic       wake,
  input  logic       link_dis,
  input  logic       dwell_done,
  output lts_state_e nxt
);
  logic ph_done, ph_tmo;

  always_comb begin
    ph_done = (cur == ST_CONFIG) ? cfg_done : rec_done;
    ph_tmo  = (cur == ST_CONFIG) ? cfg_tmo  : rec_tmo;
    nxt     = cur;
    case (cur)
      ST_DETECT:   if (det_done) nxt = ST_POLLING;
      ST_POLLING: begin
        if (poll_done)     nxt = ST_CONFIG;
        else if (poll_tmo) nxt = ST_DETECT;
      end
      ST_CONFIG, ST_RECOVERY: begin
        if (link_dis)      nxt = ST_DISABLED;
        else if (hit_hrst) nxt = ST_HOTRST;
        else if (hit_lpbk) nxt = ST_LOOPBACK;
        else if (ph_done)  nxt = ST_L0;
        else if (ph_tmo)   nxt = ST_DETECT;
      end
      ST_L0: begin
        if (link_dis)       nxt = ST_DISABLED;
        else if (retrain)   nxt = ST_RECOVERY;
        else if (eios_seen) nxt = ST_L0S;
        else if (pm_l1_req) nxt = ST_L1;
      end
      ST_L0S:      if (fts_lock) nxt = ST_L0;
      ST_L1: begin
        if (pm_l2_req) nxt = ST_L2;
        else if (wake) nxt = ST_RECOVERY;
      end
      ST_L2:       if (wake) nxt = ST_DETECT;
      ST_HOTRST:   if (dwell_done) nxt = ST_DETECT;
      ST_LOOPBACK: if (eios_seen) nxt = ST_DETECT;
      ST_DISABLED: if (!link_dis) nxt = ST_DETECT;
      default:     nxt = ST_DETECT;
    endcase
  end

endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
  import lts_pkg::*;
#(
  parameter int PAIR_NEED   = 2,
  parameter int HRST_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       det_done,
  input  logic       poll_done,
  input  logic       poll_tmo,
  input  logic       cfg_done,
  input  logic       cfg_tmo,
  input  logic       rec_done,
  input  logic       rec_tmo,
  input  logic       os_vld,
  input  logic [1:0] os_type,
  input  logic       os_lpbk,
  input  logic       os_hrst,
  input  logic       fts_lock,
  input  logic       retrain,
  input  logic       pm_l1_req,
  input  logic       pm_l2_req,
  input  logic       wake,
  input  logic       link_dis,
  output logic [3:0] st_code,
  output logic       link_up
);
  localparam int NRUN = 2;

  lts_state_e state_q, state_d;
  logic       link_up_q;
  logic       is_ts1, eios_seen, chg, dwell_done;
  logic [NRUN-1:0] run_bit, run_hit;

  assign is_ts1    = (os_type == OS_TS1);
  assign eios_seen = os_vld && (os_type == OS_EIOS);
  assign chg       = (state_d != state_q);
  assign run_bit   = {os_hrst, os_lpbk};

  for (genvar g = 0; g < NRUN; g++) begin : g_run
    lts_ts1_run #(.NEED(PAIR_NEED)) u_run (
      .clk(clk), .rst(rst), .clr(chg), .os_vld(os_vld),
      .os_is_ts1(is_ts1), .os_bit(run_bit[g]), .hit(run_hit[g])
    );
  end

  lts_dwell #(.CYCLES(HRST_CYCLES)) u_dwell (
    .clk(clk), .rst(rst), .run(state_q == ST_HOTRST), .done(dwell_done)
  );

  lts_next u_next (
    .cur(state_q), .det_done(det_done), .poll_done(poll_done), .poll_tmo(poll_tmo),
    .cfg_done(cfg_done), .cfg_tmo(cfg_tmo), .rec_done(rec_done), .rec_tmo(rec_tmo),
    .eios_seen(eios_seen), .hit_lpbk(run_hit[0]), .hit_hrst(run_hit[1]),
    .fts_lock(fts_lock), .retrain(retrain), .pm_l1_req(pm_l1_req),
    .pm_l2_req(pm_l2_req), .wake(wake), .link_dis(link_dis),
    .dwell_done(dwell_done), .nxt(state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_DETECT;
      link_up_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      link_up_q <= state_is_up(state_d);
    end
  end

  assign st_code = state_q;
  assign link_up = link_up_q;

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst) state_q <= ST_DISABLED); // R1
  AST_LINKUP_TRACK: assert property (@(posedge clk) disable iff (rst)
    link_up_q == state_is_up(state_q)); // R11
  AST_L1_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_L1 && $past(state_q) != ST_L1) |-> ($past(pm_l1_req) && $past(state_q) == ST_L0)); // R9
  AST_L0S_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_L0S && $past(state_q) != ST_L0S) |-> ($past(eios_seen) && $past(state_q) == ST_L0)); // R8
  AST_LPBK_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOPBACK && $past(state_q) != ST_LOOPBACK) |-> $past(os_vld && is_ts1 && os_lpbk)); // R4
  AST_HRST_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOTRST && $past(state_q) != ST_HOTRST) |-> $past(os_vld && is_ts1 && os_hrst)); // R5
  AST_HRST_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_HOTRST && $past(state_q) == ST_HOTRST) |-> $past(dwell_done)); // R7

endmodule

// File: tb/sim_link_train_seq.sv
`timescale 1ns/1ps
module sim_link_train_seq;
  localparam int NEED = 2;
  localparam int HRC  = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic det_done = 0, poll_done = 0, poll_tmo = 0, cfg_done = 0, cfg_tmo = 0;
  logic rec_done = 0, rec_tmo = 0, os_vld = 0, os_lpbk = 0, os_hrst = 0;
  logic fts_lock = 0, retrain = 0, pm_l1_req = 0, pm_l2_req = 0, wake = 0, link_dis = 0;
  logic [1:0] os_type = 2'd3;
  logic [3:0] st_code;
  logic       link_up;

  int checks = 0, fails = 0;
  int m_st = 0, m_lp = 0, m_hr = 0, m_hc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  link_train_seq #(.PAIR_NEED(NEED), .HRST_CYCLES(HRC)) u0 (
    .clk(clk), .rst(rst), .det_done(det_done), .poll_done(poll_done), .poll_tmo(poll_tmo),
    .cfg_done(cfg_done), .cfg_tmo(cfg_tmo), .rec_done(rec_done), .rec_tmo(rec_tmo),
    .os_vld(os_vld), .os_type(os_type), .os_lpbk(os_lpbk), .os_hrst(os_hrst),
    .fts_lock(fts_lock), .retrain(retrain), .pm_l1_req(pm_l1_req), .pm_l2_req(pm_l2_req),
    .wake(wake), .link_dis(link_dis), .st_code(st_code), .link_up(link_up)
  );

  task automatic clear_pulses();
    det_done = 0; poll_done = 0; poll_tmo = 0; cfg_done = 0; cfg_tmo = 0;
    rec_done = 0; rec_tmo = 0; os_vld = 0; os_lpbk = 0; os_hrst = 0; os_type = 2'd3;
    fts_lock = 0; retrain = 0; pm_l1_req = 0; pm_l2_req = 0; wake = 0;
  endtask

  // Reference: computes the state expected after the coming edge.
  task automatic step(input string tag);
    int ns = m_st;
    bit ts1 = os_vld && (os_type == 2'd0);
    bit eios = os_vld && (os_type == 2'd2);
    bit hp = ts1 && os_hrst && (m_hr == NEED - 1);
    bit lp = ts1 && os_lpbk && (m_lp == NEED - 1);
    bit up;
    if (m_st == 0 && det_done) ns = 1;
    else if (m_st == 1) begin
      if (poll_done) ns = 2; else if (poll_tmo) ns = 0;
    end else if (m_st == 2 || m_st == 3) begin
      if (link_dis) ns = 10;
      else if (hp) ns = 8;
      else if (lp) ns = 9;
      else if ((m_st == 2) ? cfg_done : rec_done) ns = 4;
      else if ((m_st == 2) ? cfg_tmo : rec_tmo) ns = 0;
    end else if (m_st == 4) begin
      if (link_dis) ns = 10; else if (retrain) ns = 3;
      else if (eios) ns = 5; else if (pm_l1_req) ns = 6;
    end else if (m_st == 5 && fts_lock) ns = 4;
    else if (m_st == 6) begin
      if (pm_l2_req) ns = 7; else if (wake) ns = 3;
    end else if (m_st == 7 && wake) ns = 0;
    else if (m_st == 8 && m_hc == HRC - 1) ns = 0;
    else if (m_st == 9 && eios) ns = 0;
    else if (m_st == 10 && !link_dis) ns = 0;
    if (rst) ns = 0;
    // run counters
    if (rst || ns != m_st) begin m_lp = 0; m_hr = 0; end
    else if (os_vld) begin
      m_lp = (ts1 && os_lpbk) ? ((m_lp < NEED - 1) ? m_lp + 1 : m_lp) : 0;
      m_hr = (ts1 && os_hrst) ? ((m_hr < NEED - 1) ? m_hr + 1 : m_hr) : 0;
    end
    m_hc = (!rst && m_st == 8 && ns == 8) ? m_hc + 1 : 0;
    m_st = ns;
    @(posedge clk); #1;
    up = (m_st >= 3 && m_st <= 6);
    checks++;
    if (st_code !== 4'(m_st) || link_up !== up) begin
      fails++;
      $display("FAIL %s: st_code=%0d link_up=%0b expected st_code=%0d link_up=%0b",
               tag, st_code, link_up, m_st, up);
    end
    clear_pulses();
  endtask

  task automatic send_os(input logic [1:0] k, input logic lb, input logic hr, input string tag);
    os_vld = 1; os_type = k; os_lpbk = lb; os_hrst = hr; step(tag);
  endtask

  task automatic to_config();
    det_done = 1; step("R2");
    poll_done = 1; step("R2");
  endtask

  task automatic to_l0();
    to_config();
    cfg_done = 1; step("R2");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    rst = 1; for (int i = 0; i < 3; i++) step("R1");
    rst = 0; step("R1");
    // R2 bring-up with an idle hold in Detect and Polling
    step("R2"); det_done = 1; step("R2"); step("R2");
    poll_done = 1; poll_tmo = 1; step("R3"); cfg_done = 1; step("R2 R11");
    // R8 fast idle side state
    send_os(2'd2, 0, 0, "R8"); wake = 1; retrain = 1; pm_l1_req = 1; step("R8");
    fts_lock = 1; step("R8");
    // R10 retrain
    retrain = 1; step("R10"); rec_done = 1; step("R10");
    // R9 power states, plus no-effect inputs in L0
    pm_l2_req = 1; wake = 1; step("R9");
    pm_l1_req = 1; step("R9"); wake = 1; step("R9"); rec_done = 1; step("R9");
    pm_l1_req = 1; step("R9"); pm_l2_req = 1; step("R9"); step("R9"); wake = 1; step("R9");
    // R3 timeouts
    det_done = 1; step("R3"); poll_tmo = 1; step("R3");
    to_config(); cfg_tmo = 1; step("R3");
    to_l0(); retrain = 1; step("R3"); rec_tmo = 1; step("R3");
    // R4 loopback pair in Configuration, R13 exit
    to_config();
    send_os(2'd0, 1, 0, "R4"); send_os(2'd0, 1, 0, "R4");
    send_os(2'd0, 1, 0, "R13"); send_os(2'd1, 0, 0, "R13"); send_os(2'd2, 0, 0, "R13");
    // R6 run broken by plain TS1, kept across idle, broken by TS2
    to_config();
    send_os(2'd0, 1, 0, "R6"); send_os(2'd0, 0, 0, "R6"); send_os(2'd0, 1, 0, "R6");
    step("R6"); send_os(2'd0, 1, 0, "R6"); send_os(2'd2, 0, 0, "R13");
    to_config();
    send_os(2'd0, 1, 0, "R6"); send_os(2'd1, 1, 0, "R6"); send_os(2'd0, 1, 0, "R6");
    cfg_done = 1; step("R6");
    // R4 pairs ignored in L0
    send_os(2'd0, 1, 0, "R4"); send_os(2'd0, 1, 0, "R4"); send_os(2'd0, 0, 1, "R5");
    send_os(2'd0, 0, 1, "R5");
    // R5 hot reset from Recovery, wins over loopback and done; R7 dwell
    retrain = 1; step("R10");
    send_os(2'd0, 1, 1, "R5"); rec_done = 1; send_os(2'd0, 1, 1, "R5");
    for (int i = 0; i < HRC; i++) step("R7");
    step("R7");
    // R12 disable
    to_config(); link_dis = 1; cfg_done = 1; step("R12"); step("R12"); step("R12");
    link_dis = 0; step("R12");
    // R14 priorities in L0
    to_l0(); link_dis = 1; retrain = 1; step("R14"); link_dis = 0; step("R12");
    to_l0(); retrain = 1; pm_l1_req = 1; os_vld = 1; os_type = 2'd2; step("R14");
    rec_done = 1; step("R14");
    pm_l1_req = 1; os_vld = 1; os_type = 2'd2; step("R14");
    fts_lock = 1; step("R14");
    // reset from an operating state
    rst = 1; step("R1"); rst = 0; step("R1");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule